// File: doc/BRIEF.md
# Clock-Stop SPI Master with Programmable Bit Clock

This block is the master end of a four-wire serial link in which the serial clock only runs while a word is moving. The bit clock is derived from the system clock by a programmable divider. Its period is the divider value plus one system cycles. With an even divider value the high phase is one cycle longer than the low phase. The select output is active low. It drops a full bit period before the first rising clock edge and rises one low-phase width after the last falling edge.

A parallel word enters through a valid/ready port. The word is shifted out most significant bit first, with data changing on falling clock edges. The returning word is sampled on rising edges and delivered with a one-cycle done pulse. The serial data output has its own drive-enable pin for a pad tri-state buffer. Drive is enabled one high-phase width after select falls and is removed at the final falling clock edge.

Back-pressure rules: `tx_ready` is high only while the block is idle. A word is taken in the cycle where `tx_valid` and `tx_ready` are both high. Data offered while `tx_ready` is low is not taken, so the source must hold it. The receive side has no back-pressure. `rx_valid` is a single-cycle strobe and the consumer must take `rx_data` at that time. `rx_data` then holds its value until the first rising clock edge of the next transfer.

Top module: `spi_clkstop_master`

## Requirements
- R1: The bit clock period is DIV+1 system cycles, where DIV is the value on `div` when the word was taken. A DIV of 0 is treated as 1.
- R2: When the effective DIV is odd, the clock high and low phases each last (DIV+1)/2 cycles.
- R3: When DIV is even (2 or more), the low phase lasts DIV/2 cycles and the high phase lasts DIV/2+1 cycles.
- R4: `ss_n` falls in the cycle after a word is taken. The first rising edge of `sclk` follows exactly one bit period later. `sclk` is low and makes no edges whenever `ss_n` is high.
- R5: `mosi_oe` rises one high-phase width after `ss_n` falls. At that point `mosi` carries bit WORD_W-1 of the taken word.
- R6: Exactly WORD_W rising edges occur per transfer. `mosi` sends the word MSB first, changing only on falling edges. `miso` is sampled on each rising edge. The first sample becomes bit WORD_W-1 of `rx_data`.
- R7: `mosi_oe` falls in the same cycle as the last falling edge of `sclk`.
- R8: `ss_n` rises one low-phase width after the last falling edge of `sclk`.
- R9: `tx_ready` is high exactly while `ss_n` is high. `tx_valid` has no effect while `tx_ready` is low, and neither do changes to `tx_data` or `div`.
- R10: `rx_valid` is high for exactly one cycle, in the cycle where `ss_n` returns high. `rx_data` then equals the word received.
- R11: After reset, `ss_n`=1, `sclk`=0, `mosi_oe`=0, `tx_ready`=1 and `rx_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div | input | DIV_W | Clock divider value, captured when a word is taken |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Block idle and able to take a word |
| tx_data | input | WORD_W | Word to send |
| rx_valid | output | 1 | One-cycle transfer-done strobe |
| rx_data | output | WORD_W | Received word |
| ss_n | output | 1 | Active-low slave select |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| mosi_oe | output | 1 | Drive enable for the serial data output pad |
| miso | input | 1 | Serial data in |

## Verification
The hardest case to reach is a transfer that is already under way while its inputs change. In this case `tx_valid` is held high and both `tx_data` and `div` are altered after select has fallen. The stimulus does exactly that, and it drops `tx_valid` in the very cycle where select returns high. The measured phase lengths and the captured words then show whether the divider and the word were latched at the start. The table of vectors walks DIV=0, odd and even values and back-to-back transfers. For each transfer, the edge-to-edge distances are compared with the phase formula.

// File: rtl/spi_cm_pkg.sv
package spi_cm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD_Z,
    ST_LEAD_D,
    ST_HIGH,
    ST_LOW,
    ST_TRAIL
  } spi_cm_state_t;
endpackage

// File: rtl/spi_cm_phase_len.sv
module spi_cm_phase_len #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_sel,
  output logic [DIV_W-1:0] lo_len,
  output logic [DIV_W-1:0] hi_len
);
  localparam int EXT_W = DIV_W + 1;

  logic [EXT_W-1:0] eff;
  logic [EXT_W-1:0] lo_x;
  logic [EXT_W-1:0] hi_x;

  always_comb begin
    eff  = (div_sel == '0) ? EXT_W'(1) : {1'b0, div_sel};
    lo_x = (eff + EXT_W'(1)) >> 1;
    hi_x = eff + EXT_W'(1) - lo_x;
  end

  assign lo_len = lo_x[DIV_W-1:0];
  assign hi_len = hi_x[DIV_W-1:0];

  // R1: the two phases add up to one bit period
  a_r1_period_sum: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, lo_len} + {1'b0, hi_len}) == (eff + EXT_W'(1)));
  // R3: high phase never shorter than low phase and at most one longer
  a_r3_phase_skew: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_len >= lo_len) && (hi_len - lo_len <= DIV_W'(1)));
endmodule

// File: rtl/spi_cm_shifter.sv
module spi_cm_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic              shift,
  input  logic              sample,
  input  logic              miso,
  output logic              mosi,
  output logic [WORD_W-1:0] rx_word
);
  localparam int SC_W = $clog2(WORD_W + 1) + 1;

  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] rx_sh;
  logic [SC_W-1:0]   n_samp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh  <= '0;
      rx_sh  <= '0;
      n_samp <= '0;
    end else begin
      if (load) begin
        tx_sh  <= load_word;
        n_samp <= '0;
      end else if (shift) begin
        tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
      end
      if (sample) begin
        rx_sh  <= {rx_sh[WORD_W-2:0], miso};
        n_samp <= n_samp + SC_W'(1);
      end
    end
  end

  assign mosi    = tx_sh[WORD_W-1];
  assign rx_word = rx_sh;

  // R6: never more than WORD_W samples in one transfer
  a_r6_sample_count: assert property (@(posedge clk) disable iff (!rst_n)
    n_samp <= SC_W'(WORD_W));
  // R6: loading and sampling never coincide
  a_r6_no_load_sample: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && sample));
endmodule

// File: rtl/spi_cm_seq.sv
module spi_cm_seq
  import spi_cm_pkg::*;
#(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [DIV_W-1:0] div,
  input  logic [DIV_W-1:0] lo_len,
  input  logic [DIV_W-1:0] hi_len,
  output logic [DIV_W-1:0] div_sel,
  output logic             load,
  output logic             shift,
  output logic             sample,
  output logic             done,
  output logic             ss_n,
  output logic             sclk,
  output logic             oe
);
  localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

  spi_cm_state_t    state;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;
  logic [BC_W-1:0]  bcnt;
  logic             tick;
  logic             last_bit;

  assign tick     = (cnt == '0);
  assign last_bit = (bcnt == BC_W'(WORD_W - 1));
  assign div_sel  = (state == ST_IDLE) ? div : div_q;
  assign load     = (state == ST_IDLE) && tx_valid;
  assign sample   = tick && ((state == ST_LEAD_D) || (state == ST_LOW));
  assign shift    = tick && (state == ST_HIGH) && !last_bit;
  assign ss_n     = (state == ST_IDLE);
  assign sclk     = (state == ST_HIGH);
  assign oe       = (state == ST_LEAD_D) || (state == ST_HIGH) || (state == ST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      div_q <= '0;
      bcnt  <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (tx_valid) begin
          div_q <= div;
          cnt   <= hi_len - DIV_W'(1);
          state <= ST_LEAD_Z;
        end
        ST_LEAD_Z: if (tick) begin
          cnt   <= lo_len - DIV_W'(1);
          state <= ST_LEAD_D;
        end else cnt <= cnt - DIV_W'(1);
        ST_LEAD_D: if (tick) begin
          cnt   <= hi_len - DIV_W'(1);
          bcnt  <= '0;
          state <= ST_HIGH;
        end else cnt <= cnt - DIV_W'(1);
        ST_HIGH: if (tick) begin
          cnt   <= lo_len - DIV_W'(1);
          bcnt  <= bcnt + BC_W'(1);
          state <= last_bit ? ST_TRAIL : ST_LOW;
        end else cnt <= cnt - DIV_W'(1);
        ST_LOW: if (tick) begin
          cnt   <= hi_len - DIV_W'(1);
          state <= ST_HIGH;
        end else cnt <= cnt - DIV_W'(1);
        ST_TRAIL: if (tick) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end else cnt <= cnt - DIV_W'(1);
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R4: clock stays low while select is inactive
  a_r4_no_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ss_n |-> !sclk);
  // R4: a taken word pulls select low on the next cycle
  a_r4_select_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ss_n);
  // R7: data drive only inside an active select window
  a_r7_oe_in_select: assert property (@(posedge clk) disable iff (!rst_n)
    oe |-> !ss_n);
  // R10: done is a single-cycle strobe coinciding with select release
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ss_n && !$past(ss_n)));
  // R12-style latch check for R9: divider copy is stable while busy
  a_r9_div_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!ss_n && !$past(ss_n)) |-> $stable(div_q));
endmodule

// File: rtl/spi_clkstop_master.sv
module spi_clkstop_master #(
  parameter int WORD_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  div,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [WORD_W-1:0] tx_data,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              ss_n,
  output logic              sclk,
  output logic              mosi,
  output logic              mosi_oe,
  input  logic              miso
);
  logic [DIV_W-1:0] div_sel;
  logic [DIV_W-1:0] lo_len;
  logic [DIV_W-1:0] hi_len;
  logic             load;
  logic             shift;
  logic             sample;

  spi_cm_phase_len #(.DIV_W(DIV_W)) u_len (
    .clk     (clk),
    .rst_n   (rst_n),
    .div_sel (div_sel),
    .lo_len  (lo_len),
    .hi_len  (hi_len)
  );

  spi_cm_seq #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_valid (tx_valid),
    .div      (div),
    .lo_len   (lo_len),
    .hi_len   (hi_len),
    .div_sel  (div_sel),
    .load     (load),
    .shift    (shift),
    .sample   (sample),
    .done     (rx_valid),
    .ss_n     (ss_n),
    .sclk     (sclk),
    .oe       (mosi_oe)
  );

  spi_cm_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .load_word (tx_data),
    .shift     (shift),
    .sample    (sample),
    .miso      (miso),
    .mosi      (mosi),
    .rx_word   (rx_data)
  );

  assign tx_ready = ss_n;

  // R9: a word offered while busy leaves select low the next cycle
  a_r9_busy_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (!ss_n || rx_valid));
endmodule

// File: tb/spi_clkstop_master_tb.sv
module spi_clkstop_master_tb;
  localparam int CLK_P  = 10;
  localparam int WORD_W = 8;
  localparam int DIV_W  = 8;
  localparam int NVEC   = 8;
  // {div, tx word, slave word}
  localparam logic [23:0] VEC [NVEC] = '{
    {8'd0,  8'hA5, 8'h3C},
    {8'd1,  8'h01, 8'h80},
    {8'd2,  8'hFF, 8'h00},
    {8'd3,  8'h5A, 8'hC3},
    {8'd4,  8'h80, 8'h01},
    {8'd7,  8'h96, 8'h69},
    {8'd10, 8'h33, 8'hE7},
    {8'd2,  8'h00, 8'hFF}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [DIV_W-1:0]  div = '0;
  logic              tx_valid = 1'b0;
  logic              tx_ready;
  logic [WORD_W-1:0] tx_data = '0;
  logic              rx_valid;
  logic [WORD_W-1:0] rx_data;
  logic              ss_n, sclk, mosi, mosi_oe, miso;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  logic [WORD_W-1:0] slv_word = '0;
  logic [WORD_W-1:0] slv_sh = '0;
  logic [WORD_W-1:0] slv_cap = '0;

  always #(CLK_P/2) clk = ~clk;

  spi_clkstop_master #(.WORD_W(WORD_W), .DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .div(div), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_data(rx_data), .ss_n(ss_n), .sclk(sclk), .mosi(mosi),
    .mosi_oe(mosi_oe), .miso(miso)
  );

  // slave model: drives on falling edges, captures on rising edges
  assign miso = slv_sh[WORD_W-1];
  always @(negedge ss_n) begin
    slv_sh  = slv_word;
    slv_cap = '0;
  end
  always @(negedge sclk) if (!ss_n) slv_sh = {slv_sh[WORD_W-2:0], 1'b0};
  always @(posedge sclk) slv_cap = {slv_cap[WORD_W-2:0], mosi};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // runs one transfer; disturb holds tx_valid high with other data/div while busy
  task automatic run_xfer(input logic [7:0] d, input logic [7:0] tw,
                          input logic [7:0] sw, input bit disturb);
    int eff, lo, hi, per, t, nrise, t_rise, t_fall, t_first, t_oe_on, t_oe_off;
    int bad_hi, bad_lo, ndone, t_done;
    logic p_sclk, p_oe;
    eff = (d == 0) ? 1 : d;
    per = eff + 1;
    if (eff % 2 == 1) begin lo = per / 2; hi = per / 2; end   // R2
    else begin lo = eff / 2; hi = eff / 2 + 1; end            // R3
    slv_word = sw;
    @(negedge clk);
    chk("R9 ready when idle", tx_ready, 1);
    div = d; tx_data = tw; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = disturb; tx_data = ~tw; div = d + 8'd5;
    chk("R4 select low after accept", ss_n, 0);
    t = 0; nrise = 0; t_rise = -1; t_fall = -1; t_first = -1;
    t_oe_on = -1; t_oe_off = -1; bad_hi = 0; bad_lo = 0; ndone = 0; t_done = -1;
    p_sclk = sclk; p_oe = mosi_oe;
    while (ss_n == 1'b0 && t < 5000) begin
      @(negedge clk);
      t++;
      if (ss_n) tx_valid = 1'b0;
      if (disturb && !ss_n && tx_ready) bad_lo++;
      if (sclk && !p_sclk) begin
        nrise++;
        if (nrise == 1) t_first = t;
        else if (t - t_fall != lo) bad_lo++;
        t_rise = t;
      end
      if (!sclk && p_sclk) begin
        if (t - t_rise != hi) bad_hi++;
        t_fall = t;
      end
      if (mosi_oe && !p_oe) begin
        t_oe_on = t;
        chk("R5 first bit is MSB", mosi, tw[7]);
      end
      if (!mosi_oe && p_oe) t_oe_off = t;
      if (rx_valid) begin ndone++; t_done = t; end
      p_sclk = sclk; p_oe = mosi_oe;
    end
    chk("R1 lead to first rise equals period", t_first, per);
    chk("R5 drive enable after high phase", t_oe_on, hi);
    chk("R2 R3 high phase widths", bad_hi, 0);
    chk("R2 R3 low phase widths / R9 busy", bad_lo, 0);
    chk("R6 rising edge count", nrise, WORD_W);
    chk("R7 drive off at last fall", t_oe_off, t_fall);
    chk("R8 select trail equals low phase", t - t_fall, lo);
    chk("R10 done with select release", t_done, t);
    chk("R10 received word", rx_data, sw);
    chk("R6 slave captured word", slv_cap, tw);
    @(negedge clk);
    chk("R10 done lasts one cycle", rx_valid, 0);
    chk("R9 back to ready", tx_ready, 1);
    if (disturb) chk("R9 no second transfer", ss_n, 1);
  endtask

  initial begin
    #(CLK_P * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    #(CLK_P * 2 + 3);
    chk("R11 reset ss_n", ss_n, 1);
    chk("R11 reset sclk", sclk, 0);
    chk("R11 reset oe", mosi_oe, 0);
    chk("R11 reset tx_ready", tx_ready, 1);
    chk("R11 reset rx_valid", rx_valid, 0);
    rst_n = 1'b1;
    // R4: idle with no start produces no clock
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (sclk || !ss_n) chk("R4 idle quiet", {ss_n, sclk}, 2'b10);
    end
    chk("R4 idle quiet end", {ss_n, sclk}, 2'b10);
    for (int v = 0; v < NVEC; v++)
      run_xfer(VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0);
    // R9: busy-time start, data and divider changes must be ignored
    run_xfer(8'd3, 8'hC6, 8'h2D, 1'b1);
    run_xfer(8'd6, 8'h71, 8'h9E, 1'b1);
    // R11: reset mid-transfer returns to idle state
    @(negedge clk);
    div = 8'd5; tx_data = 8'hAA; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (9) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R11 reset mid-transfer ss_n", ss_n, 1);
    chk("R11 reset mid-transfer oe", mosi_oe, 0);
    chk("R11 reset mid-transfer sclk", sclk, 0);
    @(negedge clk);
    rst_n = 1'b1;
    run_xfer(8'd1, 8'h4B, 8'hB4, 1'b0);
    finish_run();
  end
endmodule